// File: doc/BRIEF.md
# Accumulator Row-Pair Sequencer

This control block produces the address stream for a multi-vector multiply-accumulate that writes into a square accumulator array. A start pulse brings in a 32-bit select value, a small immediate offset, a group-count code (one, two or four groups), a source-register field, a 2-bit select-register field and a 4-bit multiplier-register field. On each following cycle the block emits one step. A step gives the source vector register, an accumulator row address and a flag that marks the odd row of a pair. After the last step it raises done for a single cycle.

The array holds VL/8 rows, and VL is a parameter. The rows are split into strides that are one, two or four times smaller than the array. The first row of the operation is the select value plus twice the immediate, reduced modulo the stride and then forced even. Each group writes an even/odd row pair. The next group starts one stride further on. The arithmetic datapath and the array storage sit outside this block and are driven by its step outputs.

Top module: `acc_row_sequencer`

## Requirements
- R1: The array has VL/8 rows (default VL=512, so 64 rows and a 6-bit row port). The group code 0, 1 or 2 selects 1, 2 or 4 groups, and the stride is the row count divided by the group count.
- R2: The first row equals (select value + offset) modulo the stride, rounded down to even. The sum wraps at 32 bits.
- R3: The offset is twice the immediate. All 3 immediate bits count for code 0. For codes 1 and 2 only the low 2 bits count, and bit 2 has no effect on any output.
- R4: An accepted start is followed, from the next cycle on, by 2*count consecutive valid steps. For group g the block emits row start+g*stride (odd flag 0) and then row start+g*stride+1 (odd flag 1).
- R5: The source register for group g is base+g, modulo 32. The base is the field itself for code 0, the field times 2 for code 1 and the field times 4 for code 2.
- R6: During an operation the select-register output shows 8 plus the latched 2-bit select field.
- R7: During an operation the multiplier-register output shows the latched 4-bit field with bit 4 held at zero, which gives registers 0 to 15.
- R8: busy is high while steps are being emitted. A start seen while busy is ignored and leaves the step stream unchanged.
- R9: done is high for exactly one cycle, the cycle after the last step. A start in that cycle is accepted.
- R10: A start with group code 3 is ignored and produces no steps.
- R11: After reset, step_valid, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| grp_code | input | 2 | 0: one group, 1: two, 2: four, 3: invalid |
| sel_value | input | 32 | Contents of the chosen select register |
| imm_off | input | 3 | Immediate offset field (row offset = 2*field) |
| src_field | input | 5 | Source-register field |
| sel_field | input | 2 | Select-register choice |
| mul_field | input | 4 | Multiplier-register field |
| busy | output | 1 | Steps are being emitted |
| step_valid | output | 1 | Step outputs are meaningful this cycle |
| step_src | output | 5 | Source vector register of this step |
| step_row | output | ROW_W (6) | Accumulator row of this step |
| step_odd | output | 1 | Step addresses the odd row of its pair |
| sel_reg | output | 5 | Select register number (8 to 11) |
| mul_reg | output | 5 | Multiplier register number (0 to 15) |
| done | output | 1 | One-cycle pulse after the last step |

## Verification
The bench drives select values near zero, odd values just below a stride boundary, and all-ones values that wrap at 32 bits. A design that did the modulo before adding the offset, or that left the start row odd, would place the first pair one row off or straddle two pairs. It sets immediate bit 2 for the multi-group codes, and a design that kept that bit would shift every row by 8. It fires starts in the middle of an operation and in the done cycle. A sequencer that restarted while busy, or that refused to accept a start in the done cycle, would show up as broken or missing streams. It also checks for wrong source-base scaling and for group code 3 being taken as valid.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [1:0] {
    GRP_ONE  = 2'd0,
    GRP_TWO  = 2'd1,
    GRP_FOUR = 2'd2,
    GRP_BAD  = 2'd3
  } grp_code_e;

  // log2 of the group count
  function automatic logic [1:0] grp_shift(input logic [1:0] code);
    return (code == GRP_FOUR) ? 2'd2 : (code == GRP_TWO) ? 2'd1 : 2'd0;
  endfunction

  // doubled immediate; bit 2 only counts for a single group
  function automatic logic [3:0] row_offset(input logic [1:0] code, input logic [2:0] imm);
    return (code == GRP_ONE) ? {imm, 1'b0} : {1'b0, imm[1:0], 1'b0};
  endfunction

  // first source register, scaled by the group count
  function automatic logic [4:0] src_base(input logic [1:0] code, input logic [4:0] fld);
    case (code)
      GRP_TWO:  return {fld[3:0], 1'b0};
      GRP_FOUR: return {fld[2:0], 2'b00};
      default:  return fld;
    endcase
  endfunction

endpackage

// File: rtl/acc_seq_origin.sv
module acc_seq_origin
  import acc_seq_pkg::*;
#(
  parameter int VL = 512,
  localparam int ROWS  = VL / 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic [1:0]       grp_code,
  input  logic [31:0]      sel_value,
  input  logic [2:0]       imm_off,
  input  logic [4:0]       src_field,
  output logic [ROW_W-1:0] first_row,
  output logic [ROW_W:0]   stride,
  output logic [4:0]       first_src,
  output logic [1:0]       last_grp
);

  // (sel + off) mod strd, made even; strd is a power of two no larger than ROWS
  function automatic logic [ROW_W-1:0] origin_of(input logic [31:0] s,
                                                 input logic [3:0]  o,
                                                 input logic [ROW_W:0] strd);
    logic [31:0] t;
    logic [ROW_W-1:0] m;
    t = s + 32'(o);
    m = strd[ROW_W-1:0] - ROW_W'(1);
    return t[ROW_W-1:0] & m & ~ROW_W'(1);
  endfunction

  logic [1:0] sh;

  always_comb begin
    sh        = grp_shift(grp_code);
    stride    = (ROW_W+1)'(ROWS) >> sh;
    first_row = origin_of(sel_value, row_offset(grp_code, imm_off), stride);
    first_src = src_base(grp_code, src_field);
    last_grp  = (2'd1 << sh) - 2'd1;
  end

endmodule

// File: rtl/acc_seq_stepper.sv
module acc_seq_stepper (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       code_ok,
  input  logic [1:0] last_grp,
  output logic       accept,
  output logic       active,
  output logic [1:0] grp,
  output logic       odd,
  output logic       last_step,
  output logic       done
);

  logic [1:0] last_q;

  assign accept    = start && code_ok && !active;
  assign last_step = active && odd && (grp == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      grp    <= 2'd0;
      odd    <= 1'b0;
      last_q <= 2'd0;
      done   <= 1'b0;
    end else begin
      done <= last_step;
      if (accept) begin
        active <= 1'b1;
        grp    <= 2'd0;
        odd    <= 1'b0;
        last_q <= last_grp;
      end else if (active) begin
        if (last_step) begin
          active <= 1'b0;
        end else begin
          odd <= ~odd;
          if (odd) grp <= grp + 2'd1;
        end
      end
    end
  end

  // R9: done never lasts two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: an even step is always followed by its odd partner
  a_r4_odd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    active && !odd |=> active && odd);
  // R8: once busy, the block stays busy until the last step
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    active && !last_step |=> active);

endmodule

// File: rtl/acc_row_sequencer.sv
module acc_row_sequencer
  import acc_seq_pkg::*;
#(
  parameter int VL = 512,
  localparam int ROWS  = VL / 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       grp_code,
  input  logic [31:0]      sel_value,
  input  logic [2:0]       imm_off,
  input  logic [4:0]       src_field,
  input  logic [1:0]       sel_field,
  input  logic [3:0]       mul_field,
  output logic             busy,
  output logic             step_valid,
  output logic [4:0]       step_src,
  output logic [ROW_W-1:0] step_row,
  output logic             step_odd,
  output logic [4:0]       sel_reg,
  output logic [4:0]       mul_reg,
  output logic             done
);

  function automatic logic [ROW_W-1:0] row_at(input logic [ROW_W-1:0] org,
                                              input logic [1:0]       g,
                                              input logic [ROW_W:0]   strd,
                                              input logic             o);
    logic [ROW_W+2:0] acc;
    acc = (ROW_W+3)'(org) + (ROW_W+3)'(g) * (ROW_W+3)'(strd) + (ROW_W+3)'(o);
    return acc[ROW_W-1:0];
  endfunction

  logic [ROW_W-1:0] first_row, org_q;
  logic [ROW_W:0]   stride, stride_q;
  logic [4:0]       first_src, base_q;
  logic [1:0]       last_grp, grp;
  logic [1:0]       self_q;
  logic [3:0]       mulf_q;
  logic             accept, active, odd, last_step;
  logic             code_ok;

  assign code_ok = (grp_code != GRP_BAD);

  acc_seq_origin #(.VL(VL)) u_origin (
    .grp_code (grp_code),
    .sel_value(sel_value),
    .imm_off  (imm_off),
    .src_field(src_field),
    .first_row(first_row),
    .stride   (stride),
    .first_src(first_src),
    .last_grp (last_grp)
  );

  acc_seq_stepper u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .code_ok  (code_ok),
    .last_grp (last_grp),
    .accept   (accept),
    .active   (active),
    .grp      (grp),
    .odd      (odd),
    .last_step(last_step),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      org_q    <= '0;
      stride_q <= '0;
      base_q   <= '0;
      self_q   <= '0;
      mulf_q   <= '0;
    end else if (accept) begin
      org_q    <= first_row;
      stride_q <= stride;
      base_q   <= first_src;
      self_q   <= sel_field;
      mulf_q   <= mul_field;
    end
  end

  assign busy       = active;
  assign step_valid = active;
  assign step_odd   = odd;
  assign step_row   = row_at(org_q, grp, stride_q, odd);
  assign step_src   = base_q + 5'(grp);
  assign sel_reg    = 5'd8 + 5'(self_q);
  assign mul_reg    = {1'b0, mulf_q};

  // R4: the odd step addresses the row right after its even partner
  a_r4_pair_rows: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_odd |=> step_valid && step_odd && (step_row == $past(step_row) + ROW_W'(1)));
  // R4: the next group begins one stride past the previous pair
  a_r4_group_advance: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_odd |=> !step_valid ||
      (step_row == $past(step_row) - ROW_W'(1) + ROW_W'($past(stride_q))));
  // R5: the source register is held within a pair and steps by one across groups
  a_r5_src_pair: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_odd |=> step_src == $past(step_src));
  a_r5_src_next: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_odd |=> !step_valid || (step_src == $past(step_src) + 5'd1));
  // R2: every pair starts on an even row
  a_r2_even_pair: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_odd |-> !step_row[0]);
  // R7: multiplier register stays in the low sixteen
  a_r7_mul_low: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> !mul_reg[4]);
  // R8: a start while busy does not disturb the latched stride
  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(stride_q));

endmodule

// File: tb/acc_row_sequencer_test.sv
module acc_row_sequencer_test;

  localparam int ROWS = 64;

  typedef struct {
    int src;
    int row;
    int odd;
    int selr;
    int mulr;
  } step_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  grp_code = 2'd0;
  logic [31:0] sel_value = '0;
  logic [2:0]  imm_off = '0;
  logic [4:0]  src_field = '0;
  logic [1:0]  sel_field = '0;
  logic [3:0]  mul_field = '0;
  logic        busy, step_valid, step_odd, done;
  logic [4:0]  step_src, sel_reg, mul_reg;
  logic [5:0]  step_row;

  int checks = 0;
  int errors = 0;
  step_t q[$];
  bit exp_done = 0;

  always #2.5 clk = ~clk;

  acc_row_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .grp_code(grp_code),
    .sel_value(sel_value), .imm_off(imm_off), .src_field(src_field),
    .sel_field(sel_field), .mul_field(mul_field), .busy(busy),
    .step_valid(step_valid), .step_src(step_src), .step_row(step_row),
    .step_odd(step_odd), .sel_reg(sel_reg), .mul_reg(mul_reg), .done(done)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference: expand one operation into its step list
  task automatic expand();
    int n, strd, off, base;
    longint s;
    n    = 1 << grp_code;
    strd = ROWS / n;
    off  = (grp_code == 0) ? imm_off * 2 : (imm_off % 4) * 2;
    s    = (longint'(sel_value) + off) % strd;
    s    = s - (s % 2);
    base = (src_field * n) % 32;
    for (int g = 0; g < n; g++) begin
      for (int i = 0; i < 2; i++) begin
        step_t st;
        st.src  = (base + g) % 32;
        st.row  = int'(s) + g * strd + i;
        st.odd  = i;
        st.selr = 8 + sel_field;
        st.mulr = mul_field;
        q.push_back(st);
      end
    end
  endtask

  // advance model by one edge, then compare every output
  task automatic tick();
    bit was_busy;
    was_busy = (q.size() > 0);
    exp_done = (q.size() == 1);
    if (was_busy) void'(q.pop_front());
    if (start && grp_code != 2'd3 && !was_busy) expand();
    @(posedge clk);
    @(negedge clk);
    check("R4 step_valid", step_valid, q.size() > 0);
    check("R8 busy", busy, q.size() > 0);
    check("R9 done", done, exp_done);
    if (q.size() > 0 && step_valid) begin
      check("R2/R4 row", step_row, q[0].row);
      check("R4 odd", step_odd, q[0].odd);
      check("R5 src", step_src, q[0].src);
      check("R6 sel_reg", sel_reg, q[0].selr);
      check("R7 mul_reg", mul_reg, q[0].mulr);
    end
  endtask

  task automatic run_op(logic [31:0] sv, logic [2:0] im, logic [1:0] gc,
                        logic [4:0] sf, logic [1:0] rs, logic [3:0] mf);
    sel_value = sv; imm_off = im; grp_code = gc;
    src_field = sf; sel_field = rs; mul_field = mf;
    start = 1'b1;
    tick();
    start = 1'b0;
    while (q.size() > 0) tick();
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 valid", step_valid, 0);
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5 sweep over codes, select values and offsets
    for (int gc = 0; gc < 3; gc++) begin
      for (int k = 0; k < 6; k++) begin
        logic [31:0] sv;
        case (k)
          0: sv = 32'd0;
          1: sv = 32'd15;
          2: sv = 32'd31;
          3: sv = 32'd62;
          4: sv = 32'hFFFF_FFFF;
          default: sv = 32'h1234_5677;
        endcase
        for (int im = 0; im < 8; im += 3)
          run_op(sv, 3'(im), 2'(gc), 5'(7 * k + gc + 3), 2'(k), 4'(k + 9));
      end
    end

    // R3: bit 2 of the immediate must not move rows for multi-group codes
    run_op(32'd3, 3'd5, 2'd1, 5'd9, 2'd1, 4'd2);
    run_op(32'd3, 3'd1, 2'd1, 5'd9, 2'd1, 4'd2);
    run_op(32'd3, 3'd7, 2'd2, 5'd6, 2'd2, 4'd15);

    // R8: start pulses while busy are ignored
    sel_value = 32'd21; imm_off = 3'd2; grp_code = 2'd2;
    src_field = 5'd5; sel_field = 2'd3; mul_field = 4'd4;
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    sel_value = 32'd40; grp_code = 2'd0; src_field = 5'd30; start = 1'b1;
    tick();
    tick();
    start = 1'b0;
    while (q.size() > 0) tick();
    tick();

    // R9: start held high is taken again in the done cycle
    sel_value = 32'd9; imm_off = 3'd3; grp_code = 2'd1; src_field = 5'd17;
    start = 1'b1;
    repeat (12) tick();
    start = 1'b0;
    while (q.size() > 0) tick();
    tick();

    // R10: group code 3 produces nothing
    grp_code = 2'd3; start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    check("R10 no steps", step_valid, 0);
    check("R10 not busy", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog act 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule